// File: doc/BRIEF.md
# Memory Bus Cycle Controller

This block runs the external memory read and write cycles of a processor core. The core offers one access at a time on a request port. The controller places the address on the bus and drives the active-low memory and write strobes. It steers the data bus direction and returns read data on a response strobe. A slow memory stretches any access by holding READY low, and the controller reports each stretched clock on a WAIT output.

A DMA master can take the external bus by pulling the active-low HOLD input. The controller gives up the bus only at a legal boundary. It completes the access in flight, and also one directly following access if the core has one queued. It then turns off every bus and strobe driver and raises hold acknowledge. Back-to-back accesses are capped at a fixed run length. After that run, one idle clock is forced. The tri-state bus is modelled as data values plus separate output enables.

Top module: `membus_ctrl`

## Requirements
- R1: After reset, memen_n and we_n are high, dbin, wait_o, holda, data_oe and rsp_valid are low, and addr_oe and ctl_oe are high.
- R2: A request is taken into an address phase, marked by req_ack high for exactly one clock with memen_n low and bus_addr equal to the request address. At least one data phase clock follows with memen_n still low, so an access lasts at least two clocks.
- R3: During a write access data_oe is high and bus_dout equals the write data. we_n is low in the wait and data phase clocks and high in the address phase. dbin stays low.
- R4: During a read access dbin is high and data_oe is low. The value on bus_din in the data phase clock appears on rsp_rdata while rsp_valid is high, one clock after that data phase. Every access ends with exactly one rsp_valid pulse.
- R5: READY is sampled at the end of the address phase and of every wait clock. Each clock that follows a low sample is a wait clock with wait_o high and the strobes held. The number of wait clocks equals the number of consecutive low samples.
- R6: A request present at the end of a data phase starts its address phase on the next clock. No more than MAX_RUN (default 3) accesses run back to back. After the last of them, one clock with memen_n high is inserted.
- R7: HOLD low while the bus is idle raises holda on the next clock. While holda is high, addr_oe, ctl_oe and data_oe are low and dbin is high.
- R8: HOLD low during an access lets that access finish. If a request is waiting at its data phase end, exactly one more access runs. holda then rises on the clock after the last data phase, and further requests wait.
- R9: Once HOLD is sampled high in hold, holda falls on the next clock. A request that waited during hold enters its address phase one clock after that.
- R10: Outside read accesses and hold, dbin is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Request write data |
| req_ack | output | 1 | Request taken; high in the address phase |
| rsp_valid | output | 1 | One-clock pulse when an access has finished |
| rsp_rdata | output | DW | Read data captured in the data phase |
| ready | input | 1 | Memory ready |
| hold_n | input | 1 | Active-low bus request from the DMA master |
| bus_addr | output | AW | Address bus value |
| addr_oe | output | 1 | Address bus drive enable |
| bus_dout | output | DW | Data bus value driven for writes |
| data_oe | output | 1 | Data bus drive enable |
| bus_din | input | DW | Data bus value received for reads |
| memen_n | output | 1 | Active-low memory access strobe |
| we_n | output | 1 | Active-low write strobe |
| dbin | output | 1 | Data bus read direction |
| ctl_oe | output | 1 | Strobe drive enable (memen_n, we_n, dbin) |
| wait_o | output | 1 | High in each wait clock |
| holda | output | 1 | Hold acknowledge |

## Verification
The hardest case to reach is a hold request that arrives while a second access is already queued behind the one on the bus. The deferral must then cover exactly one extra access, and a third queued request must stay parked until release. The stimulus launches three back-to-back requests from a forked driver. It pulls HOLD low as soon as the first address phase is seen, then compares the clock of each acknowledge and of the holda rise against the expected offsets. A separate burst of five requests with no hold reaches the run-length cap and checks the forced idle clock.

// File: rtl/membus_pkg.sv
package membus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_WAIT = 3'd2,
    ST_DATA = 3'd3,
    ST_HOLD = 3'd4
  } bus_st_t;
endpackage

// File: rtl/membus_fsm.sv
module membus_fsm
  import membus_pkg::*;
#(
  parameter int MAX_RUN = 3
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  logic    ready,
  input  logic    hold_n,
  output bus_st_t state,
  output logic    launch
);
  localparam int RUN_W = $clog2(MAX_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(MAX_RUN);
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

  bus_st_t          state_q, state_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             extra_q, extra_d;
  logic             hold_req, follow_ok, ctl_en;

  // next-state process
  always_comb begin
    state_d   = state_q;
    run_d     = run_q;
    extra_d   = extra_q;
    launch    = 1'b0;
    hold_req  = ~hold_n;
    follow_ok = req_valid && (run_q < RUN_LIM) && !(hold_req && extra_q);
    unique case (state_q)
      ST_IDLE: begin
        if (hold_req) begin
          state_d = ST_HOLD;
          extra_d = 1'b0;
        end else if (req_valid) begin
          state_d = ST_ADDR;
          launch  = 1'b1;
          run_d   = RUN_ONE;
          extra_d = 1'b0;
        end
      end
      ST_ADDR: state_d = ready ? ST_DATA : ST_WAIT;
      ST_WAIT: if (ready) state_d = ST_DATA;
      ST_DATA: begin
        if (follow_ok) begin
          state_d = ST_ADDR;
          launch  = 1'b1;
          run_d   = run_q + RUN_ONE;
          if (hold_req) extra_d = 1'b1;
        end else begin
          state_d = hold_req ? ST_HOLD : ST_IDLE;
          run_d   = '0;
          extra_d = 1'b0;
        end
      end
      ST_HOLD: if (!hold_req) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctl_en = (state_d != state_q) || launch;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      run_q   <= '0;
      extra_q <= 1'b0;
    end else if (ctl_en) begin
      state_q <= state_d;
      run_q   <= run_d;
      extra_q <= extra_d;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/membus_dp.sv
module membus_dp
  import membus_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  bus_st_t       state,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_din,
  output logic          wr_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q,
  output logic          rsp_q
);
  logic in_data, rd_en;

  assign in_data = (state == ST_DATA);
  assign rd_en   = in_data && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (launch) begin
      wr_q    <= req_write;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= bus_din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= 1'b0;
    else        rsp_q <= in_data;
  end
endmodule

// File: rtl/membus_pins.sv
module membus_pins
  import membus_pkg::*;
(
  input  bus_st_t state,
  input  logic    wr_q,
  output logic    req_ack,
  output logic    memen_n,
  output logic    we_n,
  output logic    dbin,
  output logic    wait_o,
  output logic    holda,
  output logic    addr_oe,
  output logic    ctl_oe,
  output logic    data_oe
);
  logic in_cyc, strobe_ph;

  always_comb begin
    in_cyc    = (state == ST_ADDR) || (state == ST_WAIT) || (state == ST_DATA);
    strobe_ph = (state == ST_WAIT) || (state == ST_DATA);
    holda     = (state == ST_HOLD);
    req_ack   = (state == ST_ADDR);
    wait_o    = (state == ST_WAIT);
    memen_n   = ~in_cyc;
    we_n      = ~(strobe_ph && wr_q);
    dbin      = (in_cyc && !wr_q) || holda;
    data_oe   = in_cyc && wr_q;
    addr_oe   = ~holda;
    ctl_oe    = ~holda;
  end
endmodule

// File: rtl/membus_ctrl.sv
module membus_ctrl
  import membus_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int MAX_RUN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ack,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  input  logic          ready,
  input  logic          hold_n,
  output logic [AW-1:0] bus_addr,
  output logic          addr_oe,
  output logic [DW-1:0] bus_dout,
  output logic          data_oe,
  input  logic [DW-1:0] bus_din,
  output logic          memen_n,
  output logic          we_n,
  output logic          dbin,
  output logic          ctl_oe,
  output logic          wait_o,
  output logic          holda
);
  logic    rst_meta, rst_sync;
  bus_st_t state;
  logic    launch, wr_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  membus_fsm #(.MAX_RUN(MAX_RUN)) u_fsm (
    .clk(clk), .rst_n(rst_sync), .req_valid(req_valid), .ready(ready),
    .hold_n(hold_n), .state(state), .launch(launch)
  );

  membus_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_sync), .launch(launch), .state(state),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_din(bus_din), .wr_q(wr_q), .addr_q(bus_addr), .wdata_q(bus_dout),
    .rdata_q(rsp_rdata), .rsp_q(rsp_valid)
  );

  membus_pins u_pins (
    .state(state), .wr_q(wr_q), .req_ack(req_ack), .memen_n(memen_n),
    .we_n(we_n), .dbin(dbin), .wait_o(wait_o), .holda(holda),
    .addr_oe(addr_oe), .ctl_oe(ctl_oe), .data_oe(data_oe)
  );
endmodule

// File: rtl/membus_ctrl_chk.sv
module membus_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ack,
  input logic ready,
  input logic hold_n,
  input logic memen_n,
  input logic we_n,
  input logic dbin,
  input logic wait_o,
  input logic holda,
  input logic addr_oe,
  input logic ctl_oe,
  input logic data_oe
);
  // R2
  addr_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> (!memen_n && !req_ack));

  // R5
  wait_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> !memen_n);

  // R5
  wait_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_o && !ready) |=> wait_o);

  // R3
  write_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (data_oe && !dbin));

  // R4
  read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbin && !holda) |-> (!data_oe && !memen_n));

  // R7
  hold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    holda |-> (!addr_oe && !ctl_oe && !data_oe && dbin));

  // R9
  hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holda) |-> $past(hold_n));
endmodule

bind membus_ctrl membus_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .ready(ready), .hold_n(hold_n),
  .memen_n(memen_n), .we_n(we_n), .dbin(dbin), .wait_o(wait_o), .holda(holda),
  .addr_oe(addr_oe), .ctl_oe(ctl_oe), .data_oe(data_oe)
);

// File: tb/tb_membus_ctrl.sv
module tb_membus_ctrl;
  localparam int AW = 16;
  localparam int DW = 16;

  logic clk, rst_n;
  logic req_valid, req_write, req_ack, rsp_valid;
  logic [AW-1:0] req_addr, bus_addr;
  logic [DW-1:0] req_wdata, rsp_rdata, bus_dout, bus_din;
  logic ready, hold_n, addr_oe, data_oe, memen_n, we_n, dbin, ctl_oe, wait_o, holda;

  membus_ctrl #(.AW(AW), .DW(DW), .MAX_RUN(3)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ready(ready), .hold_n(hold_n),
    .bus_addr(bus_addr), .addr_oe(addr_oe), .bus_dout(bus_dout), .data_oe(data_oe),
    .bus_din(bus_din), .memen_n(memen_n), .we_n(we_n), .dbin(dbin), .ctl_oe(ctl_oe),
    .wait_o(wait_o), .holda(holda)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [DW-1:0] mem_val(input logic [AW-1:0] a);
    return a ^ 16'h5A3C;
  endfunction
  assign bus_din = mem_val(bus_addr);

  typedef struct {
    bit            wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    int            nwait;
  } item_t;

  item_t expq[$];
  item_t cur;
  int    ack_cyc[$];
  int    rise_cyc[$];
  int    n_cmp = 0, n_bad = 0, cyc = 0, wcnt = 0, left = 0, n_rsp = 0, n_iss = 0;
  bit    active = 0, prev_holda = 0, finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // driver: pushes the expected item, presents the request until taken
  task automatic do_req(input bit wr, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input int nw);
    item_t it;
    it.wr = wr; it.addr = a; it.wdata = d; it.nwait = nw;
    expq.push_back(it);
    n_iss++;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    do tick(); while (!req_ack);
    req_valid = 1'b0;
  endtask

  // monitor and memory model
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (holda && !prev_holda) rise_cyc.push_back(cyc);
      prev_holda = holda;
      if (rsp_valid) begin
        n_rsp++;
        chk(wcnt == cur.nwait, "R5", "wait clock count", wcnt, cur.nwait);
        if (!cur.wr)
          chk(rsp_rdata == mem_val(cur.addr), "R4", "read data", rsp_rdata, mem_val(cur.addr));
        active = 0;
      end
      if (req_ack) begin
        ack_cyc.push_back(cyc);
        if (expq.size() == 0) begin
          chk(0, "R2", "unexpected address phase", 1, 0);
        end else begin
          cur = expq.pop_front();
          chk(bus_addr == cur.addr && !memen_n, "R2", "address phase", bus_addr, cur.addr);
          chk(we_n, "R3", "we_n high in address phase", we_n, 1);
          chk(dbin == !cur.wr, "R10", "dbin in address phase", dbin, !cur.wr);
          wcnt = 0; left = cur.nwait; active = 1;
        end
        ready = (left == 0);
      end else if (active && !memen_n) begin
        if (wait_o) begin
          wcnt++;
          if (left > 0) left--;
          ready = (left == 0);
        end
        if (cur.wr)
          chk(!we_n && data_oe && !dbin && bus_dout == cur.wdata, "R3", "write drive",
              bus_dout, cur.wdata);
        else
          chk(we_n && dbin && !data_oe, "R4", "read direction", {we_n, dbin, data_oe}, 3'b110);
      end else if (!active) begin
        ready = 1'b1;
        if (!holda) chk(!dbin, "R10", "dbin idle", dbin, 0);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int c0, base;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    ready = 1; hold_n = 1;
    repeat (3) tick();
    rst_n = 1;
    repeat (4) tick();
    // R1 reset state
    chk(memen_n && we_n && !dbin && !wait_o && !holda && !data_oe && !rsp_valid
        && addr_oe && ctl_oe, "R1", "reset outputs",
        {memen_n, we_n, dbin, wait_o, holda, data_oe, addr_oe, ctl_oe}, 8'b11000011);

    // R2 R3 R4 R5: single accesses with different wait lengths
    do_req(1, 16'h1234, 16'hBEEF, 0); repeat (4) tick();
    do_req(0, 16'h00F0, 16'h0000, 0); repeat (4) tick();
    do_req(0, 16'hFFFE, 16'h0000, 2); repeat (6) tick();
    do_req(1, 16'h8001, 16'h55AA, 3); repeat (7) tick();

    // R6 back-to-back run with cap
    base = ack_cyc.size();
    do_req(0, 16'h0100, 0, 0);
    do_req(0, 16'h0102, 0, 0);
    do_req(1, 16'h0104, 16'hA001, 0);
    do_req(0, 16'h0106, 0, 0);
    do_req(1, 16'h0108, 16'hA002, 0);
    repeat (5) tick();
    chk(ack_cyc.size() == base + 5, "R6", "run ack count", ack_cyc.size() - base, 5);
    if (ack_cyc.size() == base + 5) begin
      chk(ack_cyc[base+1] - ack_cyc[base] == 2, "R6", "gap 1", ack_cyc[base+1] - ack_cyc[base], 2);
      chk(ack_cyc[base+2] - ack_cyc[base+1] == 2, "R6", "gap 2", ack_cyc[base+2] - ack_cyc[base+1], 2);
      chk(ack_cyc[base+3] - ack_cyc[base+2] == 3, "R6", "forced idle", ack_cyc[base+3] - ack_cyc[base+2], 3);
      chk(ack_cyc[base+4] - ack_cyc[base+3] == 2, "R6", "new run", ack_cyc[base+4] - ack_cyc[base+3], 2);
    end

    // R7 hold while idle, R9 pending request released
    hold_n = 0;
    tick();
    chk(holda && !addr_oe && !ctl_oe && !data_oe && dbin, "R7", "idle hold float",
        {holda, addr_oe, ctl_oe, data_oe, dbin}, 5'b10001);
    base = ack_cyc.size();
    fork do_req(0, 16'h2222, 0, 0); join_none
    repeat (3) tick();
    chk(ack_cyc.size() == base && holda, "R9", "request parked in hold", ack_cyc.size() - base, 0);
    hold_n = 1;
    c0 = cyc;
    tick();
    chk(!holda, "R9", "holda falls", holda, 0);
    tick();
    chk(ack_cyc.size() == base + 1 && ack_cyc[ack_cyc.size()-1] == c0 + 2, "R9",
        "address phase after release", ack_cyc[ack_cyc.size()-1], c0 + 2);
    repeat (4) tick();

    // R8 hold during an access, nothing queued
    base = rise_cyc.size();
    fork do_req(1, 16'h3030, 16'h7777, 1); join_none
    do tick(); while (!req_ack);
    c0 = cyc;
    hold_n = 0;
    repeat (4) tick();
    chk(rise_cyc.size() == base + 1 && rise_cyc[rise_cyc.size()-1] == c0 + 3, "R8",
        "holda after single access", rise_cyc[rise_cyc.size()-1], c0 + 3);
    hold_n = 1;
    repeat (3) tick();

    // R8 hold with a queued follower and a third request
    base = ack_cyc.size();
    fork
      begin
        do_req(0, 16'h4000, 0, 0);
        do_req(1, 16'h4002, 16'h1111, 0);
        do_req(0, 16'h4004, 0, 0);
      end
    join_none
    do tick(); while (!req_ack);
    c0 = cyc;
    hold_n = 0;
    repeat (6) tick();
    chk(ack_cyc.size() == base + 2, "R8", "one follower only", ack_cyc.size() - base, 2);
    chk(rise_cyc[rise_cyc.size()-1] == c0 + 4, "R8", "holda after follower",
        rise_cyc[rise_cyc.size()-1], c0 + 4);
    hold_n = 1;
    c0 = cyc;
    repeat (2) tick();
    chk(ack_cyc.size() == base + 3 && ack_cyc[ack_cyc.size()-1] == c0 + 2, "R9",
        "third request after release", ack_cyc[ack_cyc.size()-1], c0 + 2);
    repeat (5) tick();

    // R4 every access answered
    chk(expq.size() == 0 && n_rsp == n_iss, "R4", "responses", n_rsp, n_iss);
    summary();
  end
endmodule